// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

A 32-bit processor core that completes one instruction on every rising clock edge. It supports register add and subtract, OR with an immediate, word load, word store, branch-if-equal and an absolute jump. The core contains its own instruction memory, data memory and a 32-entry register file, so the core has no external bus. The instruction memory has a write port, and the environment uses it to place a program while the core is held in reset.

Control is decoded in two levels. A main decoder turns the 6-bit opcode into datapath steering signals and a 2-bit ALU intent code. A small local decoder turns that intent code into the 3-bit ALU operation, and it reads the function field only when the intent code says the instruction is register-to-register. The register-write debug outputs show the write that the core commits at the next rising edge. The PC output shows the address of the instruction that is executing.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low the PC is 0, and asserting rst_ni mid-run returns the PC to 0 without waiting for a clock edge. After release, execution restarts at address 0.
- R2: Every instruction other than a taken branch or a jump moves the PC to PC+4 at the next rising edge.
- R3: Opcode [31:26]=000000 is register-to-register. Funct [5:0]=100000 writes rs+rt into rd, and funct 100010 writes rs-rt into rd, where rs=[25:21], rt=[20:16] and rd=[15:11].
- R4: Opcode 001101 writes rs OR the zero-extended immediate [15:0] into rt.
- R5: Opcode 100011 loads into rt the data word at byte address rs plus the sign-extended immediate. The word index is taken from address bits [9:2].
- R6: Opcode 101011 stores rt at the word addressed as in R5 and writes no register.
- R7: Opcode 000100 compares rs and rt. If they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by two. Otherwise the next PC is PC+4. No register or memory is written.
- R8: Opcode 000010 sets the next PC to {PC+4 bits [31:28], target [25:0], 00} and writes nothing.
- R9: Register 0 always reads as zero. A write aimed at it is dropped, and rf_we_o stays low for that write.
- R10: Any opcode outside the set above writes no register and no memory, and only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_we_i | input | 1 | Instruction memory load strobe |
| imem_waddr_i | input | 8 | Word index written by the load port |
| imem_wdata_i | input | 32 | Instruction word to load |
| pc_o | output | 32 | Address of the executing instruction |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value being written |

## Verification
On every cycle, the bound checker confirms the following:
- The next-PC rules for sequential, branch and jump instructions hold.
- Stores and branches never raise a register write.
- Undefined opcodes stay silent.
- Register 0 is never reported as a write target.
- A known register-to-register function writes its rd field.

Several behaviours can only be shown by the bench's program, because the checker does not recompute data:
- The arithmetic values produced by add and subtract.
- Zero extension for the OR immediate versus sign extension for addresses.
- A store followed by loads through two different base and offset pairs that reach the same word.
- A taken branch with a negative offset.
- The fact that register 0 still reads zero after a dropped write.
- The asynchronous return to address 0.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int unsigned XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_OR    = 2'b11
  } alu_op_e;

  typedef enum logic [2:0] {
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110
  } alu_ctl_e;

  typedef struct packed {
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    reg_write;
    logic    mem_write;
    logic    branch;
    logic    jump;
    logic    ext_sign;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o
);

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = AOP_ADD;
    case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = AOP_FUNCT;
      end
      OP_ORI: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.alu_op    = AOP_OR;
      end
      OP_LW: begin
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.ext_sign   = 1'b1;
      end
      OP_SW: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
        ctrl_o.ext_sign  = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch   = 1'b1;
        ctrl_o.ext_sign = 1'b1;
        ctrl_o.alu_op   = AOP_SUB;
      end
      OP_J: begin
        ctrl_o.jump = 1'b1;
      end
      default: ;  // undefined opcode: all enables stay low
    endcase
  end

endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  alu_op_e    alu_op_i,
  input  logic [5:0] funct_i,
  output alu_ctl_e   alu_ctl_o
);

  always_comb begin
    case (alu_op_i)
      AOP_ADD: alu_ctl_o = ALU_ADD;
      AOP_SUB: alu_ctl_o = ALU_SUB;
      AOP_OR:  alu_ctl_o = ALU_OR;
      default: begin
        // funct consulted only for register-to-register ops
        case (funct_i)
          FN_SUB:  alu_ctl_o = ALU_SUB;
          default: alu_ctl_o = ALU_ADD;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_ctl_e       ctl_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o,
  output logic           zero_o
);

  always_comb begin
    case (ctl_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);

  logic [W-1:0] regs_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = (ra_i == '0) ? '0 : regs_q[ra_i];
  assign rd_b_o = (rb_i == '0) ? '0 : regs_q[rb_i];

endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 256,
  parameter int unsigned DMEM_DEPTH = 256,
  localparam int unsigned IMEM_AW   = $clog2(IMEM_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               imem_we_i,
  input  logic [IMEM_AW-1:0] imem_waddr_i,
  input  logic [XLEN-1:0]    imem_wdata_i,
  output logic [XLEN-1:0]    pc_o,
  output logic               rf_we_o,
  output logic [4:0]         rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o
);

  localparam int unsigned DMEM_AW = $clog2(DMEM_DEPTH);

  logic [XLEN-1:0] pc_q, pc_p4, pc_next, br_off;
  logic [XLEN-1:0] instr;
  logic [XLEN-1:0] rs_val, rt_val, ext_imm, alu_b, alu_y, dmem_rdata;
  logic [4:0]      wa;
  logic            alu_zero, dmem_we, take_br;
  ctrl_t           ctrl;
  alu_ctl_e        alu_ctl;

  // fetch
  sc_ram #(.W(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_waddr_i),
    .wdata_i (imem_wdata_i),
    .raddr_i (pc_q[IMEM_AW+1:2]),
    .rdata_o (instr)
  );

  // decode
  sc_main_dec u_main_dec (
    .opcode_i (instr[31:26]),
    .ctrl_o   (ctrl)
  );

  sc_alu_dec u_alu_dec (
    .alu_op_i  (ctrl.alu_op),
    .funct_i   (instr[5:0]),
    .alu_ctl_o (alu_ctl)
  );

  assign wa = ctrl.reg_dst ? instr[15:11] : instr[20:16];

  sc_regfile #(.W(XLEN), .DEPTH(32)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (instr[25:21]),
    .rb_i   (instr[20:16]),
    .rd_a_o (rs_val),
    .rd_b_o (rt_val),
    .we_i   (rf_we_o),
    .wa_i   (wa),
    .wd_i   (rf_wdata_o)
  );

  // execute
  assign ext_imm = ctrl.ext_sign ? {{16{instr[15]}}, instr[15:0]}
                                 : {16'b0, instr[15:0]};
  assign alu_b   = ctrl.alu_src ? ext_imm : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .ctl_i  (alu_ctl),
    .a_i    (rs_val),
    .b_i    (alu_b),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  // memory
  assign dmem_we = ctrl.mem_write;

  sc_ram #(.W(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (dmem_we),
    .waddr_i (alu_y[DMEM_AW+1:2]),
    .wdata_i (rt_val),
    .raddr_i (alu_y[DMEM_AW+1:2]),
    .rdata_o (dmem_rdata)
  );

  // write back
  assign rf_wdata_o = ctrl.mem_to_reg ? dmem_rdata : alu_y;
  assign rf_we_o    = ctrl.reg_write && (wa != 5'd0);
  assign rf_waddr_o = wa;

  // next pc
  assign pc_p4   = pc_q + 32'd4;
  assign br_off  = {{14{instr[15]}}, instr[15:0], 2'b00};
  assign take_br = ctrl.branch && alu_zero;

  always_comb begin
    if (ctrl.jump)    pc_next = {pc_p4[31:28], instr[25:0], 2'b00};
    else if (take_br) pc_next = pc_p4 + br_off;
    else              pc_next = pc_p4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] instr_i,
  input logic            rf_we_i,
  input logic [4:0]      rf_waddr_i,
  input logic            dmem_we_i
);

  logic [5:0]      op;
  logic            known;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;

  assign op     = instr_i[31:26];
  assign known  = (op == OP_RTYPE) || (op == OP_ORI) || (op == OP_LW) ||
                  (op == OP_SW) || (op == OP_BEQ) || (op == OP_J);
  assign seq_pc = pc_i + 32'd4;
  assign br_pc  = seq_pc + {{14{instr_i[15]}}, instr_i[15:0], 2'b00};
  assign jmp_pc = {seq_pc[31:28], instr_i[25:0], 2'b00};

  a_r2_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_BEQ && op != OP_J) |=> pc_i == $past(seq_pc));

  a_r3_rd_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RTYPE && (instr_i[5:0] == FN_ADD || instr_i[5:0] == FN_SUB) &&
     instr_i[15:11] != 5'd0) |-> (rf_we_i && rf_waddr_i == instr_i[15:11]));

  a_r6_store_no_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SW) |-> (dmem_we_i && !rf_we_i));

  a_r7_branch_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ) |=> (pc_i == $past(seq_pc) || pc_i == $past(br_pc)));

  a_r7_branch_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ) |-> (!rf_we_i && !dmem_we_i));

  a_r8_jump_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_J) |=> pc_i == $past(jmp_pc));

  a_r9_no_r0_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_i |-> (rf_waddr_i != 5'd0));

  a_r10_unknown_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> (!rf_we_i && !dmem_we_i));

endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_i       (pc_o),
  .instr_i    (instr),
  .rf_we_i    (rf_we_o),
  .rf_waddr_i (rf_waddr_o),
  .dmem_we_i  (dmem_we)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  import sc_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        imem_we;
  logic [7:0]  imem_waddr;
  logic [31:0] imem_wdata;
  logic [31:0] pc_o;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sc_core u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_we_i    (imem_we),
    .imem_waddr_i (imem_waddr),
    .imem_wdata_i (imem_wdata),
    .pc_o         (pc_o),
    .rf_we_o      (rf_we_o),
    .rf_waddr_o   (rf_waddr_o),
    .rf_wdata_o   (rf_wdata_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {OP_RTYPE, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(int tgt);
    return {OP_J, 26'(tgt)};
  endfunction

  localparam int NPROG = 20;
  localparam logic [31:0] PROG [NPROG] = '{
    enc_i(OP_ORI, 0, 1, 16'h00F0),   // 0
    enc_i(OP_ORI, 0, 2, 16'h8001),   // 4
    enc_r(1, 2, 3, FN_ADD),          // 8
    enc_r(1, 2, 4, FN_SUB),          // 12
    enc_i(OP_SW, 1, 4, 16'h0008),    // 16
    enc_i(OP_LW, 1, 5, 16'h0008),    // 20
    enc_i(OP_ORI, 0, 6, 16'h0100),   // 24
    enc_i(OP_LW, 6, 7, 16'hFFF8),    // 28
    enc_r(1, 2, 0, FN_ADD),          // 32
    enc_r(0, 1, 8, FN_ADD),          // 36
    enc_i(OP_BEQ, 5, 7, 16'h0002),   // 40
    enc_i(OP_ORI, 0, 9, 16'hDEAD),   // 44
    enc_i(OP_ORI, 0, 9, 16'hBEEF),   // 48
    enc_i(OP_BEQ, 1, 2, 16'h0005),   // 52
    enc_i(6'h3F, 1, 9, 16'h1234),    // 56
    enc_j(18),                       // 60
    enc_i(OP_ORI, 0, 11, 16'h0001),  // 64
    enc_i(OP_ORI, 0, 11, 16'h0002),  // 68
    enc_r(5, 4, 10, FN_SUB),         // 72
    enc_i(OP_BEQ, 0, 0, 16'hFFFF)    // 76
  };

  typedef struct packed {
    logic [7:0]  req;
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
  } step_t;

  localparam int NSTEP = 17;
  localparam step_t STEPS [NSTEP] = '{
    '{8'd4,  32'd0,  1'b1, 5'd1,  32'h0000_00F0},  // R4
    '{8'd4,  32'd4,  1'b1, 5'd2,  32'h0000_8001},  // R4 zero extension
    '{8'd3,  32'd8,  1'b1, 5'd3,  32'h0000_80F1},  // R3 add
    '{8'd3,  32'd12, 1'b1, 5'd4,  32'hFFFF_80EF},  // R3 sub
    '{8'd6,  32'd16, 1'b0, 5'd0,  32'h0},          // R6 store
    '{8'd5,  32'd20, 1'b1, 5'd5,  32'hFFFF_80EF},  // R5 load
    '{8'd4,  32'd24, 1'b1, 5'd6,  32'h0000_0100},  // R4
    '{8'd5,  32'd28, 1'b1, 5'd7,  32'hFFFF_80EF},  // R5 negative offset
    '{8'd9,  32'd32, 1'b0, 5'd0,  32'h0},          // R9 write to r0
    '{8'd9,  32'd36, 1'b1, 5'd8,  32'h0000_00F0},  // R9 r0 reads zero
    '{8'd7,  32'd40, 1'b0, 5'd0,  32'h0},          // R7 taken
    '{8'd7,  32'd52, 1'b0, 5'd0,  32'h0},          // R7 not taken
    '{8'd10, 32'd56, 1'b0, 5'd0,  32'h0},          // R10
    '{8'd8,  32'd60, 1'b0, 5'd0,  32'h0},          // R8
    '{8'd8,  32'd72, 1'b1, 5'd10, 32'h0},          // R8 landing, R3 sub
    '{8'd7,  32'd76, 1'b0, 5'd0,  32'h0},          // R7 backward
    '{8'd7,  32'd76, 1'b0, 5'd0,  32'h0}           // R7 self loop
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(5ns * 20000);
    errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni     = 1'b0;
    imem_we    = 1'b0;
    imem_waddr = '0;
    imem_wdata = '0;
    repeat (2) @(negedge clk);
    chk(pc_o == 32'd0, "R1", "pc in reset", pc_o, 32'd0);

    for (int i = 0; i < NPROG; i++) begin
      imem_we    = 1'b1;
      imem_waddr = 8'(i);
      imem_wdata = PROG[i];
      @(negedge clk);
    end
    imem_we = 1'b0;
    chk(pc_o == 32'd0, "R1", "pc held during load", pc_o, 32'd0);

    rst_ni = 1'b1;
    // step table: one row per executed instruction
    for (int i = 0; i < NSTEP; i++) begin
      string tag;
      tag = $sformatf("R%0d", STEPS[i].req);
      chk(pc_o == STEPS[i].pc, (i == 0) ? "R1" : "R2", $sformatf("pc step %0d", i),
          pc_o, STEPS[i].pc);
      chk(rf_we_o == STEPS[i].we, tag, $sformatf("we step %0d", i),
          32'(rf_we_o), 32'(STEPS[i].we));
      if (STEPS[i].we) begin
        chk(rf_waddr_o == STEPS[i].wa, tag, $sformatf("waddr step %0d", i),
            32'(rf_waddr_o), 32'(STEPS[i].wa));
        chk(rf_wdata_o == STEPS[i].wd, tag, $sformatf("wdata step %0d", i),
            rf_wdata_o, STEPS[i].wd);
      end
      @(negedge clk);
    end

    // R1: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    chk(pc_o == 32'd0, "R1", "async reset pc", pc_o, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    chk(pc_o == 32'd0, "R1", "restart pc", pc_o, 32'd0);
    chk(rf_we_o && rf_waddr_o == 5'd1 && rf_wdata_o == 32'h0000_00F0, "R1",
        "restart first write", rf_wdata_o, 32'h0000_00F0);
    @(negedge clk);
    chk(pc_o == 32'd4, "R2", "pc after restart", pc_o, 32'd4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule